// File: doc/BRIEF.md
# Return Address Stack

This block holds return addresses for a small processor core. When the core takes a subroutine call or an interrupt, it presents the current program counter and raises the push strobe. When it executes a return, it raises the pop strobe and takes the address shown on the output. Storage is a last-in-first-out store of eight entries of 13 bits each, built as a circular buffer with a pointer that wraps modulo eight.

The stack never reports a fault. A ninth push overwrites the oldest entry, so the stack always holds the eight most recent addresses. A pop on an empty stack moves the pointer back past zero and exposes whatever entry sits there. The output always shows the current top of the stack, so a return takes the value in the same cycle that it pops. If push and pop are both raised in one cycle, the top entry is replaced and the depth does not change.

Top module: `retstack`

## Requirements
- R1: After reset, every entry holds 0 and the output shows 0.
- R2: A push with no pop stores the input as the new top, and the output shows it from the cycle after the push edge.
- R3: A pop with no push removes the top, and the output then shows the entry below it.
- R4: Eight pushes followed by eight pops return the eight addresses in reverse order of pushing.
- R5: After nine pushes, the eight pops that follow return the last eight addresses pushed, newest first. The first address pushed is lost, and the output then shows the ninth address again because the pointer has wrapped.
- R6: A pop beyond the last stored entry raises no flag. The pointer wraps, and the output shows the stale entry at the wrapped position.
- R7: A push and a pop in the same cycle replace the top entry with the input and leave the depth unchanged. A later pop then exposes the entry that was below the replaced one.
- R8: In a cycle with neither strobe, the stack contents and the output do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| pushEn | input | 1 | Push strobe (call or interrupt taken) |
| pushAddr | input | 13 | Return address to store |
| popEn | input | 1 | Pop strobe (return executed) |
| popAddr | output | 13 | Current top-of-stack address |

## Verification
The bound checker examines every cycle. It checks that a push, alone or together with a pop, makes the input address visible on the next cycle. It checks that an idle cycle leaves the output unchanged, and that a pop right after a lone push brings back the address shown before that push. The ordering across many levels can only be shown by the bench's directed sequences: eight addresses coming back in reverse order, the oldest entry lost on a ninth push, and stale data appearing after too many pops.

// File: rtl/retstack_pkg.sv
package retstack_pkg;
  parameter int unsigned STACK_DEPTH = 8;
  localparam int unsigned PTR_W = $clog2(STACK_DEPTH);

  typedef struct packed {
    logic             wrEn;
    logic [PTR_W-1:0] wrIdx;
    logic [PTR_W-1:0] topIdx;
  } stackCtlS;
endpackage

// File: rtl/retstack_ctl.sv
module retstack_ctl
  import retstack_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     pushEn,
  input  logic     popEn,
  output stackCtlS ctlS
);
  logic [PTR_W-1:0] fillPtr;
  logic [PTR_W-1:0] fillPtrNext;
  logic [PTR_W-1:0] topIdx;

  // Slot below the next free one; wraps naturally with PTR_W bits.
  assign topIdx = fillPtr - PTR_W'(1);

  always_comb begin
    fillPtrNext = fillPtr;
    unique case ({pushEn, popEn})
      2'b10:   fillPtrNext = fillPtr + PTR_W'(1);
      2'b01:   fillPtrNext = topIdx;
      default: fillPtrNext = fillPtr;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fillPtr <= '0;
    else       fillPtr <= fillPtrNext;
  end

  always_comb begin
    ctlS.wrEn   = pushEn;
    ctlS.wrIdx  = popEn ? topIdx : fillPtr;
    ctlS.topIdx = topIdx;
  end
endmodule

// File: rtl/retstack_dp.sv
module retstack_dp
  import retstack_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  stackCtlS          ctlS,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] topData
);
  logic [ADDR_W-1:0] entry [STACK_DEPTH];

  for (genvar i = 0; i < STACK_DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        entry[i] <= '0;
      else if (ctlS.wrEn && (ctlS.wrIdx == PTR_W'(i)))
        entry[i] <= wrData;
    end
  end

  assign topData = entry[ctlS.topIdx];
endmodule

// File: rtl/retstack.sv
module retstack
  import retstack_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushEn,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic              popEn,
  output logic [ADDR_W-1:0] popAddr
);
  stackCtlS ctlS;

  retstack_ctl u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .pushEn (pushEn),
    .popEn  (popEn),
    .ctlS   (ctlS)
  );

  retstack_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctlS    (ctlS),
    .wrData  (pushAddr),
    .topData (popAddr)
  );
endmodule

// File: rtl/retstack_chk.sv
module retstack_chk #(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              pushEn,
  input logic [ADDR_W-1:0] pushAddr,
  input logic              popEn,
  input logic [ADDR_W-1:0] popAddr
);
  // R2
  push_shows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && !popEn) |=> (popAddr == $past(pushAddr)));

  // R7
  replace_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && popEn) |=> (popAddr == $past(pushAddr)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pushEn && !popEn) |=> $stable(popAddr));

  // R3
  pop_restores_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !pushEn && $past(pushEn && !popEn)) |=> (popAddr == $past(popAddr, 2)));
endmodule

bind retstack retstack_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pushEn   (pushEn),
  .pushAddr (pushAddr),
  .popEn    (popEn),
  .popAddr  (popAddr)
);

// File: tb/retstack_test.sv
`timescale 1ns/1ps
module retstack_test;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pushEn = 1'b0;
  logic          popEn = 1'b0;
  logic [AW-1:0] pushAddr = '0;
  logic [AW-1:0] popAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  retstack #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .pushAddr(pushAddr),
    .popEn(popEn), .popAddr(popAddr)
  );

  function automatic logic [AW-1:0] val(int i);
    return AW'(13'h0105 + i * 13'd331);
  endfunction

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; pushEn = 1'b0; popEn = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
  endtask

  // Drive at a falling edge; result is sampled at the next falling edge.
  task automatic op(bit p, bit q, logic [AW-1:0] d);
    pushEn = p; popEn = q; pushAddr = d;
    @(negedge clk);
    pushEn = 1'b0; popEn = 1'b0;
  endtask

  task automatic t_reset();
    doReset();
    check("R1 top after reset", popAddr, '0);
    op(0, 1, '0);
    check("R1 wrapped slot after reset", popAddr, '0);
  endtask

  task automatic t_pushPop();
    doReset();
    op(1, 0, 13'h1A2B);
    check("R2 first push", popAddr, 13'h1A2B);
    op(1, 0, 13'h0C0D);
    check("R2 second push", popAddr, 13'h0C0D);
    op(0, 1, '0);
    check("R3 pop exposes lower", popAddr, 13'h1A2B);
  endtask

  task automatic t_fullOrder();
    doReset();
    for (int i = 0; i < 8; i++) op(1, 0, val(i));
    for (int k = 0; k < 8; k++) begin
      check($sformatf("R4 order level %0d", k), popAddr, val(7 - k));
      op(0, 1, '0);
    end
  endtask

  task automatic t_overflow();
    doReset();
    for (int i = 0; i < 9; i++) op(1, 0, val(i + 20));
    for (int k = 0; k < 8; k++) begin
      check($sformatf("R5 after wrap level %0d", k), popAddr, val(28 - k));
      op(0, 1, '0);
    end
    check("R5 oldest lost", popAddr, val(28));
  endtask

  task automatic t_underflow();
    doReset();
    for (int i = 0; i < 8; i++) op(1, 0, val(i + 40));
    for (int k = 0; k < 8; k++) op(0, 1, '0);
    check("R6 emptied shows slot7", popAddr, val(47));
    op(0, 1, '0);
    check("R6 extra pop stale", popAddr, val(46));
  endtask

  task automatic t_simul();
    doReset();
    op(1, 0, 13'h0111);
    op(1, 0, 13'h0222);
    op(1, 1, 13'h1333);
    check("R7 top replaced", popAddr, 13'h1333);
    op(0, 1, '0);
    check("R7 depth unchanged", popAddr, 13'h0111);
  endtask

  task automatic t_idle();
    doReset();
    op(1, 0, 13'h0ABC);
    op(1, 0, 13'h1DEF);
    pushAddr = 13'h1FFF;
    repeat (5) @(negedge clk);
    check("R8 idle top held", popAddr, 13'h1DEF);
    op(0, 1, '0);
    check("R8 idle lower held", popAddr, 13'h0ABC);
  endtask

  initial begin
    t_reset();
    t_pushPop();
    t_fullOrder();
    t_overflow();
    t_underflow();
    t_simul();
    t_idle();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule